// File: doc/BRIEF.md
# Interval-Paced Output Sample Queue

This block sits between a filter engine and the stage that consumes its results. A filter engine tends to produce results in bursts. The block holds up to four of them and releases them one at a time on an even, programmed grid of clock periods. The consumer then sees a steady stream.

A sample is written when the filter path is selected as the source and its valid strobe is high. No consumer request drives the read side. An internal interval counter decides when the oldest stored sample is put on the output, together with a one-cycle valid pulse.

The interval is set in clock periods, from 1 to 4096. When the queue is empty and the interval has already run out, a new sample goes straight to the output register and is not stored. A spacing of 1 therefore behaves as a plain fall-through stage. The block also reports full and empty. A write that arrives while the queue is full is lost, and the block records this in a sticky overflow flag that stays set until it is cleared.

Top module: `paced_out_fifo`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `empty` is 1, `full` is 0 and `overflow` is 0.
- R2: A sample is taken only in a cycle where `src_sel` and `wr_valid` are both 1. A strobe with `src_sel` at 0 has no effect: no output pulse follows and `empty` stays 1.
- R3: The queue holds at most 4 samples, and `full` is 1 while it holds 4. A write that arrives while `full` is 1 is dropped, and that sample never appears on the output.
- R4: A dropped write sets `overflow`. The flag stays at 1 until `ovf_clr` is 1 at a clock edge, which clears it.
- R5: Samples leave in the order they were written.
- R6: With spacing N, two consecutive output pulses are never closer than N cycles. While data is waiting, they are exactly N cycles apart.
- R7: `spacing` is 12 bits wide. A code of 1 to 4095 gives that many cycles, and code 0 gives 4096 cycles.
- R8: Suppose a sample is written while the queue is empty and the interval has expired. That sample shows on `out_data` with `out_valid` at 1 in the cycle right after the write edge, whatever the spacing. With spacing 1, a run of writes on consecutive cycles comes out on consecutive cycles.
- R9: An interval that runs out while the queue is empty produces no pulse. The block then waits, and the next written sample is released at once as described in R8.
- R10: `out_valid` is a one-cycle pulse, with exactly one pulse for each sample released.
- R11: `empty` is 1 exactly when no sample is stored. A sample released straight through on write is never counted as stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 1 | Filter output path selected as the write source |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 16 | Sample from the filter engine |
| spacing | input | 12 | Output interval in clock periods (0 means 4096) |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | One-cycle pulse marking a released sample |
| out_data | output | 16 | Released sample |
| full | output | 1 | Four samples stored |
| empty | output | 1 | No sample stored |
| overflow | output | 1 | Sticky flag: a write was dropped while full |

## Verification
The bench checks the pulse position cycle by cycle in several situations:
- A burst against a spacing of 4. If the reload value is off by one, the grid shifts by a cycle.
- A spacing of 1. A design that always stores first would lag the writes by one cycle instead of passing them straight through.
- A long idle gap before a write. A design that restarts the interval on the write instead of releasing at once would delay the sample.
- The 4096 code on an overfilled queue. A decoder that takes code 0 literally would release at the wrong times. A queue that overwrote on a full write would show the dropped sample or lose an older one.
The bench also checks that the overflow flag survives until it is cleared, and that strobes from an unselected source never leak through.

// File: rtl/pof_pkg.sv
// Package: shared helpers for the paced output queue.
// Assumes: spacing codes are unsigned and a code of zero means the
// largest interval the field can express.
package pof_pkg;

    // Turns a spacing code into its interval length in clock periods.
    function automatic int unsigned span_of(input int unsigned code,
                                            input int unsigned code_w);
        if (code == 0)
            return (32'd1 << code_w);
        else
            return code;
    endfunction

endpackage

// File: rtl/pof_store.sv
// Module: pof_store
// Circular sample store with one push and one pop port.
// Assumes: the caller never pushes while full and never pops while empty.
// Both may happen in the same cycle. The head entry is always visible.
module pof_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              full_o,
    output logic              empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  fill;

    // One register per slot, loaded when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (push && (wr_ptr == PTR_W'(g)))
                slot[g] <= push_data;
        end
    end

    // Advance the write pointer on each push, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (push)
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end

    // Advance the read pointer on each pop, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (pop)
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end

    // Track how many samples are held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= '0;
        else if (push && !pop)
            fill <= fill + 1'b1;
        else if (pop && !push)
            fill <= fill - 1'b1;
    end

    // Present the head entry and the occupancy flags.
    always_comb begin
        head_data = slot[rd_ptr];
        full_o    = (fill == CNT_W'(DEPTH));
        empty_o   = (fill == '0);
    end

    // R11: a pop is only ever requested on a non-empty store.
    p_pop_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty_o);

    // R3: the store never grows past its depth.
    p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> !full_o);

    // R11: a push without a pop leaves something stored.
    p_push_fills_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty_o);

endmodule

// File: rtl/pof_pacer.sv
// Module: pof_pacer
// Interval counter that decides when the next sample may leave.
// Assumes: `release_i` pulses once per sample sent. The counter reloads
// from the spacing code then and counts down to zero, where it waits.
module pof_pacer #(
    parameter int SPACE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPACE_W-1:0] spacing,
    input  logic               release_i,
    output logic               expired_o
);
    import pof_pkg::*;

    logic [SPACE_W-1:0] remain;
    logic [SPACE_W-1:0] reload;

    // Compute the count-down start value: interval length minus one.
    always_comb begin
        reload = SPACE_W'(span_of(32'(spacing), SPACE_W) - 1);
    end

    // Reload on release, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (release_i)
            remain <= reload;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    // Flag that the interval has run out.
    always_comb begin
        expired_o = (remain == '0);
    end

    // R6: after a release with spacing above one, the next cycle is blocked.
    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && spacing != SPACE_W'(1)) |=> !expired_o);

    // R6: a release is only taken once the interval has expired.
    p_release_on_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> expired_o);

endmodule

// File: rtl/pof_sticky.sv
// Module: pof_sticky
// Sticky event flag: set by an event, held until an explicit clear.
// Assumes: when set and clear arrive together, the set wins so no event is lost.
module pof_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Latch events and hold them until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    // R4: the flag is held while no clear is requested.
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R4: an event always leaves the flag set.
    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/paced_out_fifo.sv
// Module: paced_out_fifo
// Four-deep output queue whose read side is paced by an interval counter.
// Assumes: the source writes only through src_sel/wr_valid. There is no
// consumer backpressure: every released sample must be taken when offered.
module paced_out_fifo #(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 4,
    parameter int SPACE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_sel,
    input  logic               wr_valid,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [SPACE_W-1:0] spacing,
    input  logic               ovf_clr,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               full,
    output logic               empty,
    output logic               overflow
);
    logic              wr_fire;
    logic              accept;
    logic              drop;
    logic              expired;
    logic              pop;
    logic              bypass;
    logic              push;
    logic              release_s;
    logic [DATA_W-1:0] head_data;
    logic              out_valid_q;
    logic [DATA_W-1:0] out_data_q;

    // Decide what happens to an incoming sample and whether one leaves.
    always_comb begin
        wr_fire   = src_sel && wr_valid;
        accept    = wr_fire && !full;
        drop      = wr_fire && full;
        pop       = expired && !empty;
        bypass    = expired && empty && accept;
        push      = accept && !bypass;
        release_s = pop || bypass;
    end

    pof_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .head_data (head_data),
        .full_o    (full),
        .empty_o   (empty)
    );

    pof_pacer #(
        .SPACE_W (SPACE_W)
    ) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .spacing   (spacing),
        .release_i (release_s),
        .expired_o (expired)
    );

    pof_sticky u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (drop),
        .clr_i  (ovf_clr),
        .flag_o (overflow)
    );

    // Register the valid pulse for each released sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid_q <= 1'b0;
        else
            out_valid_q <= release_s;
    end

    // Capture the released sample from the head entry or straight from the input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_data_q <= '0;
        else if (pop)
            out_data_q <= head_data;
        else if (bypass)
            out_data_q <= wr_data;
    end

    // Drive the output ports from the registers.
    always_comb begin
        out_valid = out_valid_q;
        out_data  = out_data_q;
    end

    // R2: strobes without the source selected leave an empty queue empty.
    p_ignore_unsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel && empty) |=> empty);

    // R9: an expired interval with nothing to send gives no pulse.
    p_idle_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_fire) |=> !out_valid);

    // R3: a write onto a full queue that is not draining leaves it full.
    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

    // R10: a stored sample ready on an expired interval is always sent.
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !empty) |=> out_valid);

endmodule

// File: tb/paced_out_fifo_bench.sv
// Bench: directed scenarios for the paced output queue, one task each.
module paced_out_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        src_sel;
    logic        wr_valid;
    logic [15:0] wr_data;
    logic [11:0] spacing;
    logic        ovf_clr;
    logic        out_valid;
    logic [15:0] out_data;
    logic        full;
    logic        empty;
    logic        overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    paced_out_fifo u_paced_out_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .spacing   (spacing),
        .ovf_clr   (ovf_clr),
        .out_valid (out_valid),
        .out_data  (out_data),
        .full      (full),
        .empty     (empty),
        .overflow  (overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Advance one edge; inputs were set before it, outputs are sampled 1 ns after.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        src_sel  = 1'b0;
        wr_valid = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0; src_sel = 1'b0; wr_valid = 1'b0; wr_data = '0;
        spacing = 12'd1; ovf_clr = 1'b0;
        step(); step();
        rst_n = 1'b1;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(empty == 1'b1,     "R1 empty",     int'(empty), 1);
        check(full == 1'b0,      "R1 full",      int'(full), 0);
        check(overflow == 1'b0,  "R1 overflow",  int'(overflow), 0);
    endtask

    // R2: strobes with the source unselected are ignored.
    task automatic t_unselected();
        spacing = 12'd1;
        for (int i = 0; i < 6; i++) begin
            src_sel = 1'b0; wr_valid = 1'b1; wr_data = 16'(16'h0F00 + i);
            step();
            check(out_valid == 1'b0, "R2 no pulse", int'(out_valid), 0);
            check(empty == 1'b1,     "R2 empty",    int'(empty), 1);
        end
        idle(2);
    endtask

    // R8, R10: spacing 1 passes a back-to-back burst straight through.
    task automatic t_fall_through();
        spacing = 12'd1;
        for (int i = 0; i < 5; i++) begin
            src_sel = 1'b1; wr_valid = 1'b1; wr_data = 16'(16'h0100 + i);
            step();
            check(out_valid == 1'b1, "R8 pulse", int'(out_valid), 1);
            check(out_data == 16'(16'h0100 + i), "R8 data", int'(out_data), 16'h0100 + i);
            check(empty == 1'b1, "R11 bypass not stored", int'(empty), 1);
        end
        src_sel = 1'b0; wr_valid = 1'b0;
        step();
        check(out_valid == 1'b0, "R10 single pulse", int'(out_valid), 0);
        idle(2);
    endtask

    // R5, R6, R10: a burst of four with spacing 4 leaves on a 4-cycle grid in order.
    task automatic t_spaced_burst();
        spacing = 12'd4;
        for (int i = 0; i < 20; i++) begin
            src_sel = (i < 4); wr_valid = (i < 4); wr_data = 16'(16'h0200 + i);
            step();
            begin
                bit ev = ((i % 4) == 0) && (i / 4 < 4);
                check(out_valid == ev, "R6 pulse position", int'(out_valid), int'(ev));
                if (ev)
                    check(out_data == 16'(16'h0200 + i / 4), "R5 order", int'(out_data), 16'h0200 + i / 4);
            end
        end
        check(empty == 1'b1, "R11 drained", int'(empty), 1);
        idle(4);
    endtask

    // R9: an interval that expires while empty waits, then a write leaves at once.
    task automatic t_wait_then_write();
        spacing = 12'd5;
        src_sel = 1'b1; wr_valid = 1'b1; wr_data = 16'h0301;
        step();
        check(out_valid == 1'b1, "R9 first pulse", int'(out_valid), 1);
        src_sel = 1'b0; wr_valid = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step();
            check(out_valid == 1'b0, "R9 no idle pulse", int'(out_valid), 0);
        end
        src_sel = 1'b1; wr_valid = 1'b1; wr_data = 16'h0302;
        step();
        check(out_valid == 1'b1, "R9 immediate release", int'(out_valid), 1);
        check(out_data == 16'h0302, "R9 data", int'(out_data), 16'h0302);
        idle(6);
    endtask

    // R3, R4, R7: code 0 means 4096; a full write is dropped and flagged.
    task automatic t_overflow_4096();
        spacing = 12'd0;
        for (int i = 0; i < 4 * 4096 + 20; i++) begin
            src_sel = (i < 6); wr_valid = (i < 6); wr_data = 16'(16'h0400 + i);
            step();
            if (i == 4) check(full == 1'b1, "R3 full at four", int'(full), 1);
            if (i == 5) check(overflow == 1'b1, "R4 overflow set", int'(overflow), 1);
            begin
                bit ev = ((i % 4096) == 0) && (i / 4096 < 5);
                check(out_valid == ev, "R7 pulse position", int'(out_valid), int'(ev));
                if (ev)
                    check(out_data == 16'(16'h0400 + i / 4096), "R3 kept data", int'(out_data), 16'h0400 + i / 4096);
            end
        end
        check(empty == 1'b1, "R11 empty after drain", int'(empty), 1);
        check(overflow == 1'b1, "R4 sticky", int'(overflow), 1);
        ovf_clr = 1'b1;
        step();
        ovf_clr = 1'b0;
        check(overflow == 1'b0, "R4 cleared", int'(overflow), 0);
        idle(2);
    endtask

    initial begin
        t_reset();
        t_unselected();
        t_fall_through();
        t_spaced_burst();
        t_wait_then_write();
        t_overflow_4096();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule